// File: doc/BRIEF.md
# Voice Sample Prefetch Ring Cache

This block sits between a sample playback engine and host memory for a single voice (or a stereo voice pair). It keeps a 64-frame ring of audio frames so the engine can take one frame per request without waiting on memory. As frames are taken, a count of stale slots grows. Once that count covers a whole 32-byte burst, the block asks memory for the next burst. The returned data lands in the stale slots just behind the read position.

A frame is 1, 2 or 4 bytes, depending on sample width (8 or 16 bit) and channel count (mono or stereo). The fetch address runs exactly 64 frames ahead of the frame being played. A loop marker compares against that fetch address, so the loop signal fires 64 frames before the loop point is heard. Software can preload the ring words, the pointer pair and the fetch address. One use is to fill the ring with silence before playback starts.

Top module: `voice_prefetch_cache`

## Requirements
- R1: After synchronous reset, `frame_valid`, `mreq_valid` and `loop_hit` are 0.
- R2: The frame size is set by `fmt_wide` (1 = 16-bit samples) and `fmt_stereo` (1 = two channels). It is 1 byte for 8-bit mono, 2 bytes for 8-bit stereo or 16-bit mono, and 4 bytes for 16-bit stereo. `frame_out` carries the frame bytes little-endian from bit 0, with unused upper bits set to zero.
- R3: A `consume` accepted at a clock edge presents the frame stored at the read pointer on `frame_out`, with `frame_valid` high, in the following cycle. The same edge advances the read pointer (mod 64), the fetch address and the invalid count by one.
- R4: When the invalid count equals 64, `consume` is not accepted and `frame_valid` stays low.
- R5: With no fetch outstanding, a request is issued when the invalid count is at least 32 divided by the frame size. That threshold is 8 frames for 16-bit stereo, 16 frames for 8-bit stereo or 16-bit mono, and 32 frames for 8-bit mono. `mreq_addr` is (fetch address − invalid count) × frame size, in bytes.
- R6: No new request is issued until all 8 beats of 4 bytes of the previous burst have returned.
- R7: Returned beats fill consecutive ring positions starting at slot (read pointer − invalid count) mod 64. Each beat lowers the invalid count by 4 divided by the frame size.
- R8: The frame delivered for a consume is the memory frame at (fetch address − 64), where the fetch address is taken before that consume. The played position therefore trails the fetch address by 64 frames.
- R9: When the invalid count is 0, no request is issued.
- R10: A write with `sw_sel`=0 stores `sw_data` into ring word `sw_idx`, which covers ring bytes 4×`sw_idx` to 4×`sw_idx`+3 in little-endian order.
- R11: A write with `sw_sel`=1 loads the read pointer from `sw_data[5:0]` and the invalid count from `sw_data[14:8]` in one step.
- R12: A write with `sw_sel`=2 loads the fetch address from `sw_data[19:0]`.
- R13: `loop_hit` is high for one cycle, aligned with `frame_valid`, after an accepted consume that moves the fetch address onto `loop_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_wide | input | 1 | 1 = 16-bit samples |
| fmt_stereo | input | 1 | 1 = two interleaved channels |
| consume | input | 1 | Engine takes one frame |
| frame_valid | output | 1 | frame_out holds a consumed frame |
| frame_out | output | 32 | Consumed frame, zero-extended |
| loop_addr | input | 20 | Loop boundary, as a frame address |
| loop_hit | output | 1 | Fetch address reached loop_addr |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 2 | Write target: 0 ring word, 1 pointers, 2 fetch address |
| sw_idx | input | 6 | Ring word index |
| sw_data | input | 32 | Write data |
| mreq_valid | output | 1 | Burst request pulse |
| mreq_addr | output | 22 | Burst byte address |
| mrsp_valid | input | 1 | Response beat valid |
| mrsp_data | input | 32 | Response beat, byte 0 at bit 0 |

## Verification
Streaming is run in all four frame formats, each from a different start slot. The formats differ in bytes per frame, ring size and fetch threshold, so a fault in the packing, byte masking, wrap or per-beat decrement shows up in only some of them. Each stream starts with an empty ring, so the first consumes stall. A stalled-then-released consume tells apart frame gating from pointer advance.

With memory silenced, the bench pushes the invalid count to just below the threshold and then across it. This separates an off-by-one threshold from a wrong request address. A preloaded full ring checks that direct word writes land at the right byte, and that a full ring issues no fetch. A loop marker placed mid-stream shows whether the loop signal follows the fetch address or the played one.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [1:0] {
    SEL_WORD = 2'd0,
    SEL_PTRS = 2'd1,
    SEL_ADDR = 2'd2
  } sw_sel_t;

  localparam int INV_LSB = 8;

  // log2 of bytes per frame
  function automatic logic [1:0] frame_shift(input logic wide, input logic stereo);
    return 2'(wide) + 2'(stereo);
  endfunction
endpackage

// File: rtl/vpc_store.sv
module vpc_store #(
  parameter int STORE_BYTES = 256,
  localparam int BIDX_W = $clog2(STORE_BYTES)
) (
  input  logic              clk,
  input  logic              fill_en,
  input  logic [BIDX_W-1:0] fill_base,
  input  logic [BIDX_W-1:0] ring_mask,
  input  logic [31:0]       fill_data,
  input  logic              sw_en,
  input  logic [BIDX_W-3:0] sw_word,
  input  logic [31:0]       sw_data,
  input  logic [BIDX_W-1:0] rd_base,
  output logic [31:0]       rd_data
);
  logic [7:0] mem [STORE_BYTES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (fill_en)
        mem[(fill_base + BIDX_W'(i)) & ring_mask] <= fill_data[8*i +: 8];
      if (sw_en)
        mem[{sw_word, 2'(i)}] <= sw_data[8*i +: 8];
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_rd
    assign rd_data[8*g +: 8] = mem[(rd_base + BIDX_W'(g)) & ring_mask];
  end
endmodule

// File: rtl/vpc_ctrl.sv
module vpc_ctrl #(
  parameter int FRAMES      = 64,
  parameter int ADDR_W      = 20,
  parameter int BURST_BYTES = 32,
  localparam int PTR_W  = $clog2(FRAMES),
  localparam int CNT_W  = PTR_W + 1,
  localparam int BIDX_W = PTR_W + 2,
  localparam int BEATS  = BURST_BYTES / 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        shift,
  input  logic              consume,
  input  logic              ptr_wr,
  input  logic              addr_wr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] loop_addr,
  input  logic              rsp_valid,
  output logic              cons_ok,
  output logic [BIDX_W-1:0] rd_base,
  output logic [BIDX_W-1:0] ring_mask,
  output logic              fill_en,
  output logic [BIDX_W-1:0] fill_base,
  output logic              req_valid,
  output logic [ADDR_W+1:0] req_addr,
  output logic              loop_hit,
  output logic [CNT_W-1:0]  inval_o
);
  import vpc_pkg::*;

  logic [PTR_W-1:0]  rd_ptr;
  logic [CNT_W-1:0]  inval;
  logic [ADDR_W-1:0] cur;
  logic              busy;
  logic [BEAT_W-1:0] beat_cnt;
  logic [BIDX_W-1:0] wr_byte;

  logic [CNT_W-1:0]  per_burst, per_beat;
  logic [PTR_W-1:0]  slot;
  logic [ADDR_W-1:0] fetch_frame;

  assign per_burst   = CNT_W'(BURST_BYTES >> shift);
  assign per_beat    = CNT_W'(4 >> shift);
  assign ring_mask   = BIDX_W'((FRAMES << shift) - 1);
  assign rd_base     = BIDX_W'(rd_ptr) << shift;
  assign slot        = rd_ptr - inval[PTR_W-1:0];
  assign fetch_frame = cur - ADDR_W'(inval);
  assign cons_ok     = consume && (inval != CNT_W'(FRAMES)) && !ptr_wr;
  assign fill_en     = busy && rsp_valid;
  assign fill_base   = wr_byte;
  assign inval_o     = inval;

  // pointer trio
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      inval  <= '0;
      cur    <= '0;
    end else begin
      if (ptr_wr) begin
        rd_ptr <= wr_data[PTR_W-1:0];
        inval  <= wr_data[INV_LSB +: CNT_W];
      end else begin
        inval <= inval + CNT_W'(cons_ok) - (fill_en ? per_beat : '0);
        if (cons_ok) rd_ptr <= rd_ptr + 1'b1;
      end
      if (addr_wr)      cur <= wr_data[ADDR_W-1:0];
      else if (cons_ok) cur <= cur + 1'b1;
    end
  end

  // burst request and fill tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      beat_cnt  <= '0;
      wr_byte   <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      loop_hit  <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      loop_hit  <= cons_ok && (cur + 1'b1 == loop_addr);
      if (fill_en) begin
        wr_byte  <= wr_byte + BIDX_W'(4);
        beat_cnt <= beat_cnt + 1'b1;
        if (beat_cnt == BEAT_W'(BEATS - 1)) busy <= 1'b0;
      end else if (!busy && !ptr_wr && inval >= per_burst) begin
        req_valid <= 1'b1;
        busy      <= 1'b1;
        beat_cnt  <= '0;
        req_addr  <= (ADDR_W+2)'(fetch_frame) << shift;
        wr_byte   <= BIDX_W'(slot) << shift;
      end
    end
  end

  p_inval_cap_r4: assert property (@(posedge clk) disable iff (rst)
    inval <= CNT_W'(FRAMES));
  p_one_request_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !$past(busy));
  p_full_idle_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ($past(inval) != '0));
  p_consume_step_r3: assert property (@(posedge clk) disable iff (rst)
    cons_ok |=> (rd_ptr == $past(rd_ptr) + 1'b1));
endmodule

// File: rtl/voice_prefetch_cache.sv
module voice_prefetch_cache #(
  parameter int FRAMES      = 64,
  parameter int ADDR_W      = 20,
  parameter int BURST_BYTES = 32,
  localparam int PTR_W       = $clog2(FRAMES),
  localparam int CNT_W       = PTR_W + 1,
  localparam int STORE_BYTES = FRAMES * 4,
  localparam int BIDX_W      = $clog2(STORE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fmt_wide,
  input  logic              fmt_stereo,
  input  logic              consume,
  output logic              frame_valid,
  output logic [31:0]       frame_out,
  input  logic [ADDR_W-1:0] loop_addr,
  output logic              loop_hit,
  input  logic              sw_wr,
  input  logic [1:0]        sw_sel,
  input  logic [BIDX_W-3:0] sw_idx,
  input  logic [31:0]       sw_data,
  output logic              mreq_valid,
  output logic [ADDR_W+1:0] mreq_addr,
  input  logic              mrsp_valid,
  input  logic [31:0]       mrsp_data
);
  import vpc_pkg::*;

  logic [1:0]        shift;
  logic              cons_ok, fill_en;
  logic [BIDX_W-1:0] rd_base, ring_mask, fill_base;
  logic [31:0]       rd_data, byte_keep;
  logic [CNT_W-1:0]  inval;

  assign shift = frame_shift(fmt_wide, fmt_stereo);

  always_comb begin
    case (shift)
      2'd0:    byte_keep = 32'h0000_00ff;
      2'd1:    byte_keep = 32'h0000_ffff;
      default: byte_keep = 32'hffff_ffff;
    endcase
  end

  vpc_ctrl #(.FRAMES(FRAMES), .ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .shift(shift), .consume(consume),
    .ptr_wr(sw_wr && sw_sel == SEL_PTRS),
    .addr_wr(sw_wr && sw_sel == SEL_ADDR),
    .wr_data(sw_data), .loop_addr(loop_addr), .rsp_valid(mrsp_valid),
    .cons_ok(cons_ok), .rd_base(rd_base), .ring_mask(ring_mask),
    .fill_en(fill_en), .fill_base(fill_base),
    .req_valid(mreq_valid), .req_addr(mreq_addr),
    .loop_hit(loop_hit), .inval_o(inval)
  );

  vpc_store #(.STORE_BYTES(STORE_BYTES)) u_store (
    .clk(clk), .fill_en(fill_en), .fill_base(fill_base), .ring_mask(ring_mask),
    .fill_data(mrsp_data),
    .sw_en(sw_wr && sw_sel == SEL_WORD), .sw_word(sw_idx), .sw_data(sw_data),
    .rd_base(rd_base), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      frame_out   <= '0;
    end else begin
      frame_valid <= cons_ok;
      if (cons_ok) frame_out <= rd_data & byte_keep;
    end
  end

  p_stall_empty_r4: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> ($past(inval) != CNT_W'(FRAMES)));
  p_loop_aligned_r13: assert property (@(posedge clk) disable iff (rst)
    loop_hit |-> frame_valid);
endmodule

// File: tb/voice_prefetch_cache_tb.sv
module voice_prefetch_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;

  logic clk = 0, rst = 1;
  logic fmt_wide = 0, fmt_stereo = 0, consume = 0;
  logic frame_valid, loop_hit, mreq_valid;
  logic [31:0] frame_out;
  logic [ADDR_W-1:0] loop_addr = '1;
  logic sw_wr = 0;
  logic [1:0] sw_sel = 0;
  logic [5:0] sw_idx = 0;
  logic [31:0] sw_data = 0;
  logic [ADDR_W+1:0] mreq_addr;
  logic mrsp_valid = 0;
  logic [31:0] mrsp_data = 0;

  int total = 0, bad = 0;
  bit mem_en = 1;
  int req_count, overlap;
  logic [ADDR_W+1:0] first_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_prefetch_cache u_dut (
    .clk(clk), .rst(rst), .fmt_wide(fmt_wide), .fmt_stereo(fmt_stereo),
    .consume(consume), .frame_valid(frame_valid), .frame_out(frame_out),
    .loop_addr(loop_addr), .loop_hit(loop_hit),
    .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_idx(sw_idx), .sw_data(sw_data),
    .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data)
  );

  function automatic logic [7:0] mb(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h3c;
  endfunction

  function automatic logic [31:0] exp_frame(input int f, input int fb);
    logic [31:0] v = '0;
    for (int j = 0; j < fb; j++) v[8*j +: 8] = mb(f*fb + j);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  initial begin
    int left = 0;
    int a = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        left = 0; req_count = 0; overlap = 0; mrsp_valid = 0;
      end else begin
        if (mreq_valid && left > 0) overlap++;
        if (mem_en && left > 0) begin
          mrsp_valid = 1;
          for (int j = 0; j < 4; j++) mrsp_data[8*j +: 8] = mb(a + j);
          a += 4; left--;
        end else mrsp_valid = 0;
        if (mreq_valid) begin
          if (req_count == 0) first_req = mreq_addr;
          req_count++; left = 8; a = int'(mreq_addr);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; consume = 0; sw_wr = 0;
    repeat (2) @(negedge clk); rst = 0;
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk); sw_wr = 1; sw_sel = sel; sw_idx = idx; sw_data = d;
    @(negedge clk); sw_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check(!frame_valid && !mreq_valid && !loop_hit, "R1", {frame_valid, mreq_valid, loop_hit}, 0);
  endtask

  // R2 R3 R7 R8 R12 R13: stream from an empty ring
  task automatic t_stream(input bit w, input bit s, input int start, input int rd, input int n, input int loop_off);
    int fb = 1 << (int'(w) + int'(s));
    int got = 0, cyc = 0;
    bit frame_ok = 1, loop_ok = 1;
    do_reset();
    mem_en = 1; fmt_wide = w; fmt_stereo = s;
    loop_addr = ADDR_W'(start + 64 + loop_off);
    sw_write(2'd2, 0, 32'(start + 64));
    sw_write(2'd1, 0, (32'd64 << 8) | 32'(rd));
    @(negedge clk); consume = 1;
    while (got < n && cyc < 4000) begin
      @(posedge clk); #1; cyc++;
      if (frame_valid) begin
        logic [31:0] e = exp_frame(start + got, fb);
        bit lh = (start + 64 + got + 1) == (start + 64 + loop_off);
        if (frame_out !== e) begin
          frame_ok = 0;
          check(0, "R2/R3/R7/R8 frame", frame_out, e);
        end
        if (loop_hit !== lh) begin
          loop_ok = 0;
          check(0, "R13 loop_hit", 32'(loop_hit), 32'(lh));
        end
        got++;
        if (got == n) consume = 0;
      end
    end
    consume = 0;
    check(got == n, "R3 frame count", got, n);
    check(frame_ok, "R8 lagged frame data", 0, 0);
    check(loop_ok, "R13 loop alignment", 0, 0);
    check(first_req == (ADDR_W+2)'(start * fb), "R5 R12 first address", 32'(first_req), 32'(start*fb));
    check(overlap == 0, "R6 overlapping request", overlap, 0);
  endtask

  task automatic t_threshold();
    do_reset();
    mem_en = 0; fmt_wide = 1; fmt_stereo = 1;
    sw_write(2'd2, 0, 32'd1000);
    sw_write(2'd1, 0, (32'd7 << 8) | 32'd3);
    repeat (5) @(negedge clk);
    check(req_count == 0, "R5 below threshold", req_count, 0);
    consume = 1; @(negedge clk); consume = 0;
    repeat (3) @(negedge clk);
    check(req_count == 1, "R5 at threshold", req_count, 1);
    check(first_req == 22'((1001 - 8) * 4), "R5 address", 32'(first_req), (1001-8)*4);
    mem_en = 1;
  endtask

  task automatic t_stall();
    bit seen = 0;
    do_reset();
    mem_en = 0; fmt_wide = 0; fmt_stereo = 0;
    sw_write(2'd2, 0, 32'd200);
    sw_write(2'd1, 0, 32'd64 << 8);
    @(negedge clk); consume = 1;
    repeat (6) begin @(posedge clk); #1; if (frame_valid) seen = 1; end
    consume = 0;
    check(!seen, "R4 stall on empty", 32'(seen), 0);
    check(req_count == 1 && first_req == 22'd136, "R5 R6 pending request", 32'(first_req), 136);
    mem_en = 1;
  endtask

  task automatic t_preload();
    logic [31:0] e [3] = '{32'h33, 32'h44, 32'h80};
    do_reset();
    mem_en = 1; fmt_wide = 0; fmt_stereo = 0;
    for (int i = 0; i < 32; i++) sw_write(2'd0, 6'(i), i == 0 ? 32'h44332211 : 32'h80808080);
    sw_write(2'd1, 0, 32'd2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); consume = 1;
      @(posedge clk); #1; consume = 0;
      check(frame_valid && frame_out == e[k], "R10 R11 preload frame", frame_out, e[k]);
    end
    repeat (4) @(negedge clk);
    check(req_count == 0, "R9 full ring idle", req_count, 0);
  endtask

  initial begin
    t_reset();
    t_stream(1'b1, 1'b0, 300, 0, 150, 10);
    t_stream(1'b0, 1'b0, 77, 37, 150, 200);
    t_stream(1'b0, 1'b1, 512, 50, 120, 64);
    t_stream(1'b1, 1'b1, 1000, 63, 120, 0);
    t_threshold();
    t_stall();
    t_preload();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule